// File: doc/BRIEF.md
# Two-Mode Signal Strength Sequencer

This block sequences a received-signal-strength measurement for an external quasi-peak detector and an external ADC. When a measurement starts, it first discharges the detector by closing a reset switch for a fixed number of clocks. It then closes a track switch so the detector follows the incoming peak. While the measurement enable stays high, it starts one ADC conversion per fixed period. Each completed result is written into a strength register. A status flag shows that the current measurement has produced at least one result.

Two modes decide what happens when the enable drops. In sample mode the track switch opens and the held voltage receives one last conversion, provided the pulse was long enough to produce a result. After that the register is frozen. In continuous mode the sequencer simply stops: a conversion that is still in flight is discarded, and the register keeps the newest completed value. An enable pulse too short to reach the first conversion produces nothing.

Top module: `sigstr_seq`

## Requirements
- R1: A synchronous reset opens both switches, drives `convStart` low, clears `strength` to 0 and clears `strengthFresh`, and returns the sequencer to idle.
- R2: A rising edge of `measEn`, sampled at a clock edge, closes the reset switch (`rstSwClosed`=1) for exactly RST_CYC (default 7) cycles, then releases it.
- R3: `holdSwClosed` is 1 only after the reset phase and only while `measEn` stays high. It opens in the cycle after the clock edge that first samples `measEn` low.
- R4: `convStart` is a one-cycle pulse. The first one comes in the cycle after `measEn` has been sampled high at PERIOD (default 32) consecutive edges. Further pulses follow every PERIOD cycles while it stays high.
- R5: `strength` takes `adcData` only at an edge where `adcValid` is 1 and a started conversion is still outstanding. Otherwise it holds its value.
- R6: In sample mode (`modeCont`=0), when `measEn` falls after at least one periodic conversion, exactly one final `convStart` is issued in the next cycle with the track switch open. The register takes that result (or an earlier outstanding one) and is then frozen, with no further starts.
- R7: In continuous mode (`modeCont`=1), a fall of `measEn` stops all conversions with no final start. A result still in flight is discarded.
- R8: An enable pulse sampled high at fewer than PERIOD edges starts no conversion and leaves `strength` unchanged.
- R9: A rising edge of `measEn` during a final conversion restarts the sequence with a full reset phase and drops the pending result.
- R10: `strengthFresh` becomes 1 when the first result of a measurement is loaded. It is cleared in the cycle after a rising edge of `measEn` is sampled. A result arriving at the same edge as that rising edge is not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digital clock |
| rst | input | 1 | Synchronous reset, active high |
| modeCont | input | 1 | 1 = continuous mode, 0 = sample mode |
| measEn | input | 1 | Measurement enable |
| adcData | input | DATA_W | Conversion result |
| adcValid | input | 1 | One-cycle flag marking adcData valid |
| rstSwClosed | output | 1 | 1 closes the peak-detector reset switch |
| holdSwClosed | output | 1 | 1 closes the track/hold switch |
| convStart | output | 1 | One-cycle conversion start |
| strength | output | DATA_W | Signal strength register |
| strengthFresh | output | 1 | A result has been loaded in this measurement |

## Verification
Two collisions can fall in one cycle, and the bench provokes both. The first is a returning ADC result and a new enable rising edge. The bench does a sample-mode fall right after a periodic start, then re-raises the enable so that its rising edge is sampled at the same edge as that conversion's valid flag. The restart must win: the register keeps its old value and the fresh flag drops. The second is a periodic start and a continuous-mode fall in the same cycle. The bench lowers the enable in the very cycle a start is visible, and the discarded result must never reach the register. A behavioural model checks every cycle.

// File: rtl/sigstr_pkg.sv
package sigstr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RESET,
    PH_TRACK,
    PH_FSTART,
    PH_FWAIT
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic clearFresh;
  } dpStrobe_t;

endpackage

// File: rtl/sigstr_ctrl.sv
module sigstr_ctrl
  import sigstr_pkg::*;
#(
  parameter int RST_CYC = 7,
  parameter int PERIOD  = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      modeCont,
  input  logic      measEn,
  input  logic      adcValid,
  output dpStrobe_t strobe,
  output logic      rstSwClosed,
  output logic      holdSwClosed,
  output logic      convStart
);

  localparam int CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] PER_LAST = CNT_W'(PERIOD - 1);

  phase_t phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic enPrev;
  logic pending, pendingNext;
  logic pulseOk;

  logic rise, periodEnd, loadNow, contStop, haveResult;

  assign rise       = measEn & ~enPrev;
  assign periodEnd  = (phase == PH_TRACK) && (cnt == PER_LAST);
  assign convStart  = periodEnd || (phase == PH_FSTART);
  assign loadNow    = adcValid && pending && !rise;
  assign contStop   = (phase == PH_TRACK) && !measEn && modeCont;
  assign haveResult = pulseOk || periodEnd;

  assign rstSwClosed  = (phase == PH_RESET);
  assign holdSwClosed = (phase == PH_TRACK);

  assign strobe.load       = loadNow;
  assign strobe.clearFresh = rise;

  always_comb begin
    phaseNext = phase;
    cntNext   = cnt;
    if (rise) begin
      phaseNext = PH_RESET;
      cntNext   = '0;
    end else begin
      unique case (phase)
        PH_RESET: begin
          if (!measEn) begin
            phaseNext = PH_IDLE;
          end else begin
            cntNext = cnt + 1'b1;
            if (cnt == RST_LAST) phaseNext = PH_TRACK;
          end
        end
        PH_TRACK: begin
          if (!measEn) begin
            phaseNext = (!modeCont && haveResult) ? PH_FSTART : PH_IDLE;
          end else begin
            cntNext = periodEnd ? '0 : cnt + 1'b1;
          end
        end
        PH_FSTART: phaseNext = PH_FWAIT;
        PH_FWAIT:  if (loadNow) phaseNext = PH_IDLE;
        default:   phaseNext = PH_IDLE;
      endcase
    end
  end

  // restart beats a stop, a stop beats a new start, a start beats a completion
  always_comb begin
    if (rise)           pendingNext = 1'b0;
    else if (contStop)  pendingNext = 1'b0;
    else if (convStart) pendingNext = 1'b1;
    else if (loadNow)   pendingNext = 1'b0;
    else                pendingNext = pending;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      enPrev  <= 1'b0;
      pending <= 1'b0;
      pulseOk <= 1'b0;
    end else begin
      phase   <= phaseNext;
      cnt     <= cntNext;
      enPrev  <= measEn;
      pending <= pendingNext;
      if (rise)           pulseOk <= 1'b0;
      else if (periodEnd) pulseOk <= 1'b1;
    end
  end

endmodule

// File: rtl/sigstr_dpath.sv
module sigstr_dpath
  import sigstr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] adcData,
  output logic [DATA_W-1:0] strength,
  output logic              strengthFresh
);

  always_ff @(posedge clk) begin
    if (rst) begin
      strength      <= '0;
      strengthFresh <= 1'b0;
    end else begin
      if (strobe.load) strength <= adcData;
      if (strobe.clearFresh)  strengthFresh <= 1'b0;
      else if (strobe.load)   strengthFresh <= 1'b1;
    end
  end

endmodule

// File: rtl/sigstr_seq.sv
module sigstr_seq
  import sigstr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RST_CYC = 7,
  parameter int PERIOD  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeCont,
  input  logic              measEn,
  input  logic [DATA_W-1:0] adcData,
  input  logic              adcValid,
  output logic              rstSwClosed,
  output logic              holdSwClosed,
  output logic              convStart,
  output logic [DATA_W-1:0] strength,
  output logic              strengthFresh
);

  dpStrobe_t strobe;

  sigstr_ctrl #(.RST_CYC(RST_CYC), .PERIOD(PERIOD)) ctrl_i (
    .clk(clk), .rst(rst), .modeCont(modeCont), .measEn(measEn),
    .adcValid(adcValid), .strobe(strobe), .rstSwClosed(rstSwClosed),
    .holdSwClosed(holdSwClosed), .convStart(convStart)
  );

  sigstr_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rst(rst), .strobe(strobe), .adcData(adcData),
    .strength(strength), .strengthFresh(strengthFresh)
  );

endmodule

// File: rtl/sigstr_chk.sv
module sigstr_chk #(
  parameter int DATA_W  = 8,
  parameter int RST_CYC = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              rstSwClosed,
  input logic              holdSwClosed,
  input logic              convStart,
  input logic              adcValid,
  input logic [DATA_W-1:0] strength,
  input logic              strengthFresh
);

  // length of the current reset-switch closure, counted in earlier cycles
  logic [15:0] runLen;
  always_ff @(posedge clk) begin
    if (rst)              runLen <= '0;
    else if (rstSwClosed) runLen <= runLen + 16'd1;
    else                  runLen <= '0;
  end

  assert_rst_len_R2: assert property (@(posedge clk) disable iff (rst)
    rstSwClosed |-> (runLen < 16'(RST_CYC)));

  assert_track_after_reset_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(holdSwClosed) |-> $past(rstSwClosed));

  assert_no_start_in_reset_R4: assert property (@(posedge clk) disable iff (rst)
    convStart |-> !rstSwClosed);

  assert_load_needs_valid_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(strength) |-> ($past(adcValid) || $past(rst)));

  assert_fresh_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(strengthFresh) |-> $past(adcValid));

endmodule

bind sigstr_seq sigstr_chk #(.DATA_W(DATA_W), .RST_CYC(RST_CYC)) chk_i (
  .clk(clk), .rst(rst), .rstSwClosed(rstSwClosed), .holdSwClosed(holdSwClosed),
  .convStart(convStart), .adcValid(adcValid), .strength(strength),
  .strengthFresh(strengthFresh)
);

// File: tb/sigstr_seq_tb_top.sv
module sigstr_seq_tb_top;

  localparam int DW  = 8;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic modeCont = 1'b0;
  logic measEn = 1'b0;
  logic adcValid = 1'b0;
  logic [DW-1:0] adcData = '0;
  logic rstSwClosed, holdSwClosed, convStart, strengthFresh;
  logic [DW-1:0] strength;

  sigstr_seq dut_i (
    .clk(clk), .rst(rst), .modeCont(modeCont), .measEn(measEn),
    .adcData(adcData), .adcValid(adcValid), .rstSwClosed(rstSwClosed),
    .holdSwClosed(holdSwClosed), .convStart(convStart),
    .strength(strength), .strengthFresh(strengthFresh)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // behavioural reference: 0 idle, 1 reset phase, 2 tracking, 3 final start, 4 final wait
  int mPh, mAge, mStr;
  bit mPend, mOk, mEnPrev, mFresh;
  bit tRise, tLoad, tEnd, tConv, tOkNow;

  always @(posedge clk) begin
    if (rst) begin
      mPh = 0; mAge = 0; mStr = 0;
      mPend = 0; mOk = 0; mEnPrev = 0; mFresh = 0;
    end else begin
      tEnd   = (mPh == 2) && (mAge % 32 == 31);
      tConv  = tEnd || (mPh == 3);
      tRise  = measEn && !mEnPrev;
      tLoad  = adcValid && mPend && !tRise;
      tOkNow = mOk || tEnd;
      if (tLoad) begin mStr = int'(adcData); mFresh = 1; end
      if (tRise) mPend = 0;
      else if (mPh == 2 && !measEn && modeCont) mPend = 0;
      else if (tConv) mPend = 1;
      else if (tLoad) mPend = 0;
      mOk = tRise ? 1'b0 : tOkNow;
      if (tRise) begin
        mPh = 1; mAge = 0; mFresh = 0;
      end else begin
        case (mPh)
          1: if (!measEn) mPh = 0;
             else begin mAge++; if (mAge == 7) mPh = 2; end
          2: if (!measEn) mPh = (!modeCont && tOkNow) ? 3 : 0;
             else mAge++;
          3: mPh = 4;
          4: if (tLoad) mPh = 0;
          default: mPh = 0;
        endcase
      end
      mEnPrev = measEn;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(rstSwClosed == (mPh == 1), "R2", "rstSwClosed", rstSwClosed, mPh == 1);
      check(holdSwClosed == (mPh == 2), "R3", "holdSwClosed", holdSwClosed, mPh == 2);
      check(convStart == (((mPh == 2) && (mAge % 32 == 31)) || mPh == 3), "R4",
            "convStart", convStart, ((mPh == 2) && (mAge % 32 == 31)) || mPh == 3);
      check(int'(strength) == mStr, "R5", "strength", int'(strength), mStr);
      check(strengthFresh == mFresh, "R10", "strengthFresh", strengthFresh, mFresh);
    end
  end

  // ADC model: fixed latency, one result per start
  int adcQ[$];
  int nextVal = 33;
  int lastAdc = 0;
  always @(negedge clk) begin
    adcValid = 1'b0;
    if (rst) adcQ.delete();
    else begin
      for (int i = 0; i < adcQ.size(); i++) adcQ[i] = adcQ[i] - 1;
      if (adcQ.size() > 0 && adcQ[0] == 0) begin
        void'(adcQ.pop_front());
        adcValid = 1'b1;
        adcData  = DW'(nextVal);
        lastAdc  = nextVal;
        nextVal  = (nextVal * 5 + 17) % 256;
      end
      if (convStart) adcQ.push_back(LAT);
    end
  end

  int convCount = 0;
  always @(posedge clk) if (!rst && convStart) convCount++;

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  int c0, s1, n;
  initial begin
    repeat (3) @(negedge clk);
    check(rstSwClosed == 0 && holdSwClosed == 0, "R1", "switches in reset", rstSwClosed + holdSwClosed, 0);
    check(strength == 0, "R1", "strength in reset", int'(strength), 0);
    check(convStart == 0 && strengthFresh == 0, "R1", "start/fresh in reset", convStart + strengthFresh, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // sample mode, long pulse
    modeCont = 1'b0; c0 = convCount; measEn = 1'b1;
    repeat (80) @(negedge clk);
    measEn = 1'b0;
    repeat (20) @(negedge clk);
    check(convCount == c0 + 3, "R4", "starts in sample pulse", convCount - c0, 3);
    check(int'(strength) == lastAdc, "R6", "frozen final value", int'(strength), lastAdc);
    check(strengthFresh == 1, "R10", "fresh after result", strengthFresh, 1);
    c0 = convCount;
    repeat (60) @(negedge clk);
    check(convCount == c0, "R6", "no start after freeze", convCount - c0, 0);

    // continuous mode, stop in the cycle of a start
    modeCont = 1'b1; measEn = 1'b1;
    do @(negedge clk); while (!convStart);
    repeat (LAT + 2) @(negedge clk);
    s1 = int'(strength);
    check(s1 == lastAdc, "R7", "continuous result loaded", s1, lastAdc);
    do @(negedge clk); while (!convStart);
    measEn = 1'b0; c0 = convCount;
    repeat (12) @(negedge clk);
    check(convCount == c0 + 1, "R7", "no start after stop", convCount - c0, 1);
    check(int'(strength) == s1, "R7", "in-flight result dropped", int'(strength), s1);

    // short pulse
    modeCont = 1'b0; s1 = int'(strength); c0 = convCount; measEn = 1'b1;
    repeat (20) @(negedge clk);
    measEn = 1'b0;
    repeat (40) @(negedge clk);
    check(convCount == c0, "R8", "short pulse starts", convCount - c0, 0);
    check(int'(strength) == s1, "R8", "short pulse strength", int'(strength), s1);
    check(strengthFresh == 0, "R8", "short pulse fresh", strengthFresh, 0);

    // restart during final conversion
    measEn = 1'b1;
    repeat (40) @(negedge clk);
    measEn = 1'b0;
    @(negedge clk);
    measEn = 1'b1; n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (rstSwClosed) n++;
    end
    check(n == 7, "R9", "reset phase after restart", n, 7);
    repeat (40) @(negedge clk);
    measEn = 1'b0;
    repeat (20) @(negedge clk);

    // collision: result returns at the edge that samples a new rising edge
    measEn = 1'b1;
    do @(negedge clk); while (!convStart);
    s1 = int'(strength);
    @(negedge clk); measEn = 1'b0;
    repeat (2) @(negedge clk); measEn = 1'b1;
    repeat (6) @(negedge clk);
    check(int'(strength) == s1, "R10", "result at restart edge ignored", int'(strength), s1);
    check(strengthFresh == 0, "R10", "fresh cleared on restart", strengthFresh, 0);
    repeat (40) @(negedge clk);

    // reset in the middle of a measurement
    modeCont = 1'b1;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(strength == 0 && strengthFresh == 0, "R1", "mid-run reset register", int'(strength), 0);
    check(rstSwClosed == 0 && holdSwClosed == 0 && convStart == 0, "R1", "mid-run reset outputs",
          rstSwClosed + holdSwClosed + convStart, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    finishRun();
  end

endmodule